// File: doc/BRIEF.md
# I2C Slave Register Port

This block puts a bank of 32-bit internal registers behind a two-wire serial bus for an external host. It samples the open-drain clock and data lines with a fast system clock. Both lines pass through a synchronizer and a glitch filter. The block finds start and stop conditions, matches its 7-bit device address and acknowledges each accepted byte by pulling the data line low. The system clock must run at least ten times faster than the bus clock. Bus timing is set entirely by the external master, so standard-mode and fast-mode rates are both handled.

One bit of the device address comes from a strap input, so two of these devices can share a bus. In a write, the first data byte after the address is a register subaddress. The bytes after it are packed most significant byte first into 32-bit words. Each complete word is handed to the register bank with a single-cycle write strobe, and the subaddress then increments. In a read, the block fetches the word at the current subaddress with a single-cycle read strobe and shifts it out. Once the master acknowledges the fourth byte of a word, the block fetches the next word. A transaction carries at most 20 data bytes, so at most five words.

Top module: `i2cs_regport`

## Requirements
- R1: During and directly after reset, `sda_oe`, `reg_wr` and `reg_rd` are all low.
- R2: A falling SDA while SCL is high is a start condition, and a rising SDA while SCL is high is a stop condition. A start condition received in the middle of a transaction (a repeated start) begins a new address phase. `sda_oe` changes only while the filtered SCL is low.
- R3: The device address is the 7-bit parameter `ADDR_BASE` (default 0x34) with bit `CS_BIT` (default 0) replaced by `cs_strap`. The first byte after a start carries this address in bits 7..1 and R/W in bit 0, where 1 means read. A matching first byte is acknowledged, whichever its R/W value, by driving SDA low during the ninth clock.
- R4: If the first byte does not match, SDA stays released, with no acknowledge and no data, and no strobe is issued until the next start condition.
- R5: In a write, the first data byte becomes the subaddress. The bytes after it form words, the first byte of each group of four landing in bits 31..24. When the fourth byte of a word arrives, `reg_wr` is high for one cycle with `reg_addr` equal to the subaddress and `reg_wdata` equal to the packed word. The subaddress then increments by one.
- R6: If a write ends with a stop while a word is incomplete, that partial word is discarded and no `reg_wr` pulse is issued for it.
- R7: A write acknowledges the subaddress byte and up to `MAX_BYTES` (20) data bytes. The data byte after the limit is not acknowledged, and the rest of the transaction is ignored.
- R8: In a read, `reg_rd` pulses for one cycle with `reg_addr` equal to the subaddress, and `reg_rdata` is taken in that same cycle. Bits 31..24 of the word are sent first, each byte most significant bit first. When the master acknowledges the fourth byte, the subaddress increments and the next word is fetched.
- R9: A master NACK after a read byte ends the read. SDA then stays released, so further clocked bytes read as 0xFF until the next start condition.
- R10: After `MAX_BYTES` bytes have been sent in one read, the block releases SDA even if the master acknowledged, and further bytes read as 0xFF.
- R11: A pulse on either line shorter than `FILT_LEN` (3) system clock cycles is ignored. It produces no extra bit, no start and no stop.
- R12: The block operates correctly for any SCL high or low phase of at least 16 system clocks, provided SDA changes at least 8 clocks after SCL falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| cs_strap | input | 1 | Strap value inserted into device address bit CS_BIT |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_addr | output | 8 | Register subaddress for both strobes |
| reg_wdata | output | 32 | Write word, valid while reg_wr is high |
| reg_rdata | input | 32 | Read word, must be valid in the cycle reg_rd is high |

## Verification
The hardest situations to reach are the ones at the byte limit. These are the 21st write byte, which must be refused, and the 21st read byte, which must find the line released although the master still acknowledges. Reaching them takes a full twenty-byte transaction driven bit by bit. The bench model of the bus master runs such transactions directly and then clocks one extra byte. It also injects a short SDA dip while SCL is high, which would otherwise look like a start followed by a stop, and a short SCL spike while SCL is low. It then checks that the word still arrives intact. Random write-then-read-back transactions at two bus speeds cover the subaddress increment and wraparound.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int SUB_W  = 8;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SACK,
        ST_WR,
        ST_RD,
        ST_RACK,
        ST_IGN
    } i2cs_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } i2cs_evt_t;

    function automatic logic [6:0] i2cs_dev_addr(input logic [6:0] base,
                                                 input int unsigned pos,
                                                 input logic strap);
        logic [6:0] r;
        r = base;
        r[pos] = strap;
        return r;
    endfunction

endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                filt_o <= 1'b1;
            else if (~|hist_q)
                filt_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_f,
    input  logic      sda_f,
    output i2cs_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop  = scl_f & scl_q & ~sda_q & sda_f;
        evt.rise  = scl_f & ~scl_q;
        evt.fall  = ~scl_f & scl_q;
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int MAX_BYTES = 20,
    localparam int CW = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  i2cs_evt_t         evt,
    input  logic              sda_f,
    input  logic [6:0]        dev,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [SUB_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output i2cs_state_e       state_o,
    output logic [CW-1:0]     bytecnt_o
);
    localparam logic [CW-1:0] CAP = CW'(MAX_BYTES);

    i2cs_state_e       state;
    logic [3:0]        bitcnt;
    logic [7:0]        sh;
    logic              rw, have_sub, mack;
    logic [SUB_W-1:0]  sub;
    logic [CW-1:0]     bytecnt;
    logic [23:0]       wword;
    logic [WORD_W-1:0] rword, wdata_q;
    logic              wr_q, rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            sh       <= '0;
            rw       <= 1'b0;
            have_sub <= 1'b0;
            mack     <= 1'b0;
            sub      <= '0;
            bytecnt  <= '0;
            wword    <= '0;
            rword    <= '0;
            wdata_q  <= '0;
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            if (wr_q) sub   <= sub + 1'b1;
            if (rd_q) rword <= reg_rdata;

            if (evt.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                bytecnt  <= '0;
                have_sub <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (evt.rise) begin
                            sh     <= {sh[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.fall && bitcnt == 4'd8) begin
                            if (sh[7:1] == dev) begin
                                rw     <= sh[0];
                                sda_oe <= 1'b1;
                                state  <= ST_SACK;
                                if (sh[0]) rd_q <= 1'b1;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    ST_SACK: begin
                        if (evt.fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state  <= ST_RD;
                                sda_oe <= ~rword[WORD_W-1];
                                rword  <= rword << 1;
                            end else begin
                                state  <= ST_WR;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR: begin
                        if (evt.rise) begin
                            sh     <= {sh[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.fall && bitcnt == 4'd8) begin
                            if (!have_sub) begin
                                sub      <= sh;
                                have_sub <= 1'b1;
                                sda_oe   <= 1'b1;
                                state    <= ST_SACK;
                            end else if (bytecnt < CAP) begin
                                bytecnt <= bytecnt + CW'(1);
                                wword   <= {wword[15:0], sh};
                                if (bytecnt[1:0] == 2'd3) begin
                                    wr_q    <= 1'b1;
                                    wdata_q <= {wword, sh};
                                end
                                sda_oe <= 1'b1;
                                state  <= ST_SACK;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    ST_RD: begin
                        if (evt.rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                bytecnt <= bytecnt + CW'(1);
                                state   <= ST_RACK;
                            end else begin
                                sda_oe <= ~rword[WORD_W-1];
                                rword  <= rword << 1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) begin
                            mack <= ~sda_f;
                            if (!sda_f && bytecnt[1:0] == 2'd0 && bytecnt < CAP) begin
                                sub  <= sub + 1'b1;
                                rd_q <= 1'b1;
                            end
                        end else if (evt.fall) begin
                            if (mack && bytecnt < CAP) begin
                                state  <= ST_RD;
                                bitcnt <= '0;
                                sda_oe <= ~rword[WORD_W-1];
                                rword  <= rword << 1;
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_wr    = wr_q;
    assign reg_rd    = rd_q;
    assign reg_addr  = sub;
    assign reg_wdata = wdata_q;
    assign state_o   = state;
    assign bytecnt_o = bytecnt;
endmodule

// File: rtl/i2cs_regport.sv
module i2cs_regport
    import i2cs_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE = 7'h34,
    parameter int         CS_BIT    = 0,
    parameter int         MAX_BYTES = 20,
    parameter int         FILT_LEN  = 3,
    localparam int        CW        = $clog2(MAX_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        cs_strap,
    output logic        sda_oe,
    output logic        reg_wr,
    output logic        reg_rd,
    output logic [7:0]  reg_addr,
    output logic [31:0] reg_wdata,
    input  logic [31:0] reg_rdata
);
    logic [1:0]  raw, filt;
    logic        scl_f, sda_f;
    logic [6:0]  dev;
    i2cs_evt_t   evt;
    i2cs_state_e eng_state;
    logic [CW-1:0] byte_cnt;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cs_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw[g]),
            .filt_o (filt[g])
        );
    end

    assign scl_f = filt[1];
    assign sda_f = filt[0];
    assign dev   = i2cs_dev_addr(ADDR_BASE, CS_BIT, cs_strap);

    i2cs_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .evt   (evt)
    );

    i2cs_engine #(.MAX_BYTES(MAX_BYTES)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sda_f     (sda_f),
        .dev       (dev),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .state_o   (eng_state),
        .bytecnt_o (byte_cnt)
    );
endmodule

// File: rtl/i2cs_regport_chk.sv
module i2cs_regport_chk
    import i2cs_pkg::*;
#(
    parameter int  MAX_BYTES = 20,
    localparam int CW = $clog2(MAX_BYTES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_f,
    input logic          sda_oe,
    input logic          reg_wr,
    input logic          reg_rd,
    input i2cs_state_e   state,
    input logic [CW-1:0] bytecnt
);
    // R2: the data line driver only moves while the clock is low
    p_oe_moves_low_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_f);

    // R4: nothing is driven once the transaction is being ignored
    p_ign_released_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGN) |-> !sda_oe);

    // R5: write strobe lasts one cycle
    p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R6: a write strobe only follows a whole word
    p_word_whole_r6: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (bytecnt[1:0] == 2'd0 && bytecnt != '0));

    // R7: byte counter never passes the cap
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        bytecnt <= CW'(MAX_BYTES));

    // R8: read strobe lasts one cycle and never meets a write strobe
    p_rd_single_r8: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));
endmodule

bind i2cs_regport i2cs_regport_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_f),
    .sda_oe  (sda_oe),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .state   (eng_state),
    .bytecnt (byte_cnt)
);

// File: tb/i2cs_regport_bench.sv
`timescale 1ns/1ps
module i2cs_regport_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        cs = 1'b0;
    logic        sda_oe, reg_wr, reg_rd;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    wire         sda_bus = m_sda & ~sda_oe;

    logic [31:0] mem     [0:255];
    logic [31:0] exp_mem [0:255];
    logic [7:0]  log_a   [0:63];
    logic [31:0] log_d   [0:63];
    int          wr_n = 0;
    logic [7:0]  tx [0:31];
    int          checks = 0, fails = 0, half = 16;
    bit          done = 0;

    always #4 clk = ~clk;

    assign reg_rdata = mem[reg_addr];

    i2cs_regport u_i2cs_regport (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus), .cs_strap(cs),
        .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (!rst && reg_wr) begin
            if (wr_n < 64) begin
                log_a[wr_n] = reg_addr;
                log_d[wr_n] = reg_wdata;
            end
            mem[reg_addr] = reg_wdata;
            wr_n++;
        end
    end

    function automatic logic [31:0] init_word(input int a);
        return (32'(a) * 32'h0101_0101) ^ 32'hA5C3_1E00;
    endfunction

    function automatic logic [6:0] exp_dev(input logic s);
        return s ? 7'h35 : 7'h34;
    endfunction

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        hclk(half / 2); m_sda = b;
        hclk(half - half / 2); m_scl = 1'b1;
        hclk(half / 2); s = sda_bus;
        hclk(half - half / 2); m_scl = 1'b0;
    endtask

    task automatic clk_bit_glitch(input logic b, output logic s);
        hclk(half / 2); m_sda = b;
        hclk(2); m_scl = 1'b1;
        hclk(2); m_scl = 1'b0;
        hclk(half - half / 2 - 4); m_scl = 1'b1;
        hclk(2); m_sda = 1'b0;
        hclk(2); m_sda = b;
        hclk(half / 2 - 4); s = sda_bus;
        hclk(half - half / 2); m_scl = 1'b0;
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; m_scl = 1'b1;
        hclk(half); m_sda = 1'b0;
        hclk(half); m_scl = 1'b0;
    endtask

    task automatic i2c_restart;
        hclk(half / 2); m_sda = 1'b1;
        hclk(half - half / 2); m_scl = 1'b1;
        hclk(half); m_sda = 1'b0;
        hclk(half); m_scl = 1'b0;
    endtask

    task automatic i2c_stop;
        hclk(half / 2); m_sda = 1'b0;
        hclk(half - half / 2); m_scl = 1'b1;
        hclk(half); m_sda = 1'b1;
        hclk(half);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit glitch, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            if (glitch) clk_bit_glitch(b[i], s);
            else        clk_bit(b[i], s);
        end
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(!give_ack, s);
    endtask

    // write subaddress then nb data bytes from tx[]; checks acks and strobes
    task automatic do_write(input logic [7:0] sub, input int nb, input bit glitch, input string req);
        logic a;
        int   bad = 0, base = wr_n, nw;
        i2c_start;
        write_byte({exp_dev(cs), 1'b0}, 1'b0, a);
        check_eq({req, " R3 address ack"}, a, 1'b1);
        write_byte(sub, 1'b0, a);
        if (!a) bad++;
        for (int i = 0; i < nb; i++) begin
            write_byte(tx[i], glitch, a);
            if (a !== (i < 20)) bad++;
        end
        check_eq({req, " R7 ack pattern mismatches"}, bad, 0);
        i2c_stop;
        hclk(4);
        nw = ((nb > 20) ? 20 : nb) / 4;
        check_eq({req, " R5 R6 write strobe count"}, wr_n - base, nw);
        for (int w = 0; w < nw; w++) begin
            logic [7:0]  ea = sub + 8'(w);
            logic [31:0] ed = {tx[4*w], tx[4*w+1], tx[4*w+2], tx[4*w+3]};
            exp_mem[ea] = ed;
            if (base + w < 64 && (base + w) < wr_n) begin
                check_eq({req, " R5 write address"}, log_a[base + w], ea);
                check_eq({req, " R5 write data"}, log_d[base + w], ed);
            end
        end
    endtask

    // set subaddress, repeated start, read nb bytes; last byte NACKed if nack_last
    task automatic do_read(input logic [7:0] sub, input int nb, input bit nack_last,
                           input int extra, input string req);
        logic a;
        logic [7:0] b, eb;
        int bad = 0;
        logic [31:0] fa = 0, fe = 0;
        i2c_start;
        write_byte({exp_dev(cs), 1'b0}, 1'b0, a);
        write_byte(sub, 1'b0, a);
        i2c_restart;
        write_byte({exp_dev(cs), 1'b1}, 1'b0, a);
        check_eq({req, " R2 R3 read address ack after repeated start"}, a, 1'b1);
        for (int j = 0; j < nb + extra; j++) begin
            read_byte(!(nack_last && j == nb - 1), b);
            if (j >= nb || j >= 20) eb = 8'hFF;
            else eb = 8'(exp_mem[sub + 8'(j / 4)] >> (24 - 8 * (j % 4)));
            if (b !== eb) begin
                if (bad == 0) begin fa = 32'(b); fe = 32'(eb); end
                bad++;
            end
        end
        check_eq({req, " R8 R9 R10 first wrong read byte"}, fa, fe);
        check_eq({req, " R8 R9 R10 read mismatches"}, bad, 0);
        i2c_stop;
    endtask

    initial begin : watchdog
        repeat (190000) @(negedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic a;
        logic [7:0] b;
        int wr0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            mem[i] = init_word(i);
            exp_mem[i] = init_word(i);
        end
        hclk(3);
        check_eq("R1 sda_oe in reset", sda_oe, 1'b0);
        check_eq("R1 strobes in reset", {reg_wr, reg_rd}, 2'b00);
        hclk(5);
        rst = 1'b0;
        hclk(2);
        check_eq("R1 sda_oe after reset", sda_oe, 1'b0);
        check_eq("R1 strobes after reset", {reg_wr, reg_rd}, 2'b00);
        hclk(20);

        // R4: wrong address (0x35 while strap low) is ignored
        wr0 = wr_n;
        i2c_start;
        write_byte({7'h35, 1'b0}, 1'b0, a);
        check_eq("R4 no ack on wrong address", a, 1'b0);
        write_byte(8'h00, 1'b0, a);
        check_eq("R4 no ack after wrong address", a, 1'b0);
        i2c_stop;
        i2c_start;
        write_byte({7'h35, 1'b1}, 1'b0, a);
        check_eq("R4 no ack on wrong read address", a, 1'b0);
        read_byte(1'b1, b);
        check_eq("R4 released during ignored read", b, 8'hFF);
        i2c_stop;
        check_eq("R4 no strobe after wrong address", wr_n - wr0, 0);

        // R5: single word
        for (int i = 0; i < 4; i++) tx[i] = 8'h11 * 8'(i + 1);
        do_write(8'h10, 4, 1'b0, "single word");

        // R7: 21 bytes, last refused
        for (int i = 0; i < 21; i++) tx[i] = 8'(8'h80 + 8'(i * 7));
        do_write(8'h20, 21, 1'b0, "byte cap");

        // R6: six bytes, second word partial
        for (int i = 0; i < 6; i++) tx[i] = 8'(8'hC0 + 8'(i));
        do_write(8'h30, 6, 1'b0, "partial word");

        // R8/R9: read two words, NACK the eighth, one extra byte must be 0xFF
        do_read(8'h20, 8, 1'b1, 1, "read two words");

        // R10: 20 bytes all acked, 21st must be released
        do_read(8'h1E, 20, 1'b0, 1, "read cap");

        // R3: strap high moves the address to 0x35
        cs = 1'b1;
        hclk(10);
        i2c_start;
        write_byte({7'h34, 1'b0}, 1'b0, a);
        check_eq("R3 0x34 refused when strap high", a, 1'b0);
        i2c_stop;
        for (int i = 0; i < 4; i++) tx[i] = 8'(8'h5A ^ 8'(i * 3));
        do_write(8'hFF, 4, 1'b0, "strap high");
        do_read(8'hFF, 4, 1'b1, 0, "strap high read");
        cs = 1'b0;
        hclk(10);

        // R11: glitched bytes still produce the right word
        for (int i = 0; i < 4; i++) tx[i] = 8'(8'hF0 ^ 8'(i * 17));
        do_write(8'h40, 4, 1'b1, "R11 glitch");
        do_read(8'h40, 4, 1'b1, 0, "R11 glitch read");

        // R12: random transactions at two bus speeds
        for (int t = 0; t < 5; t++) begin
            logic [7:0] sub = 8'($urandom_range(0, 255));
            int nw = $urandom_range(1, 5);
            half = (t % 2 == 0) ? 24 : 16;
            for (int i = 0; i < 4 * nw; i++) tx[i] = 8'($urandom);
            do_write(sub, 4 * nw, 1'b0, "R12 random");
            do_read(sub, 4 * nw, 1'b1, 0, "R12 random read");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule